// File: doc/BRIEF.md
# SDRAM Burst Column Sequencer

This block produces the column address stream for a single SDRAM read or write burst. A controller presents a start column, a burst length code and a burst order together with a one-cycle start strobe. Starting on the following cycle, the block emits one column address per clock with a valid flag. It raises a last flag on the closing beat of a burst with a finite length.

Sequential bursts count upward inside an aligned block of N columns. Interleaved bursts XOR the beat number into the low bits of the start column. A full-page sequential burst walks every column of the row, wraps, and runs until it is stopped. A terminate strobe stops the stream. A fresh start strobe on any cycle abandons the running burst and begins the new one. Command decoding, bank and row handling, and the data path belong to other blocks.

Top module: `sdr_burst_col_seq`

## Requirements
- R1: While reset is asserted, and after it is released with no start, valid_o and last_o are 0.
- R2: A start_i pulse in cycle t makes valid_o 1 in cycle t+1 with col_o equal to the start_col_i value sampled in cycle t, for every order and length.
- R3: len_code_i selects the burst length: 0 gives 1 beat, 1 gives 2, 2 gives 4, 3 gives 8, and any code with bit 2 set gives a full page. A finite burst of N beats holds valid_o high for exactly N consecutive cycles.
- R4: With il_i = 0 (sequential) and length N, beat k carries the start column with its low log2(N) bits replaced by (low bits + k) mod N. The upper bits do not change.
- R5: With il_i = 1 (interleave) and length N, beat k carries the start column XOR k, with k confined to the low log2(N) bits.
- R6: A sequential full-page burst increments the column by one each cycle, wraps from 2^COL_W-1 to 0, and keeps valid_o high until a terminate or a new start.
- R7: An interleave request with a full-page length code runs as an 8-beat interleaved burst.
- R8: last_o is 1 only on the final beat of a finite burst, and valid_o falls in the next cycle unless a new start arrives. last_o is never 1 during a full-page burst.
- R9: term_i in cycle t with no start makes valid_o and last_o 0 from cycle t+1.
- R10: A start_i during a running burst abandons that burst. The next cycle shows beat 0 of the new burst, with no gap required between the two starts.
- R11: When start_i and term_i are both 1 in one cycle, the start takes effect and the terminate is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| start_i | input | 1 | Start strobe for a new burst |
| term_i | input | 1 | Terminate strobe |
| start_col_i | input | COL_W | Start column of the new burst |
| len_code_i | input | 3 | Burst length code |
| il_i | input | 1 | Burst order: 0 sequential, 1 interleave |
| col_o | output | COL_W | Column address of the current beat |
| valid_o | output | 1 | A beat is being issued this cycle |
| last_o | output | 1 | Final beat of a finite burst |

## Verification
The bench builds the block with its default COL_W of 8, so a row holds 256 columns. At that size a full-page burst can be run through a complete wrap from column 255 to 0 and on past it in a few hundred cycles. The narrow column width also puts wrap points of the aligned blocks inside sequential bursts starting near a block end within easy reach. Beside those cases the bench covers every length code, including the codes that alias to full page. It also drives restarts on the first, middle and last beat, and a start that coincides with a terminate.

// File: rtl/sdr_col_pkg.sv
package sdr_col_pkg;
  localparam int LEN_CODE_W   = 3;
  localparam int MAX_FIN_LOG  = 3;

  typedef enum logic {
    ORDER_SEQ = 1'b0,
    ORDER_IL  = 1'b1
  } burst_order_e;

  // log2 of the finite length selected by a code; bit 2 marks full page
  function automatic logic [1:0] fin_log(input logic [LEN_CODE_W-1:0] code);
    return code[1:0];
  endfunction
endpackage

// File: rtl/sdr_len_decode.sv
module sdr_len_decode
  import sdr_col_pkg::*;
#(
  parameter int COL_W = 8
) (
  input  logic [LEN_CODE_W-1:0] len_code_i,
  input  burst_order_e          order_i,
  output logic [COL_W-1:0]      mask_o,
  output logic                  full_o
);
  logic       full_req;
  logic [1:0] lg;

  assign full_req = len_code_i[2];
  // interleave cannot run a full page: fall back to the longest finite length
  assign full_o   = full_req && (order_i == ORDER_SEQ);
  assign lg       = (full_req && (order_i == ORDER_IL)) ? 2'(MAX_FIN_LOG) : fin_log(len_code_i);

  for (genvar i = 0; i < COL_W; i++) begin : g_mask
    assign mask_o[i] = full_o || (i < int'(lg));
  end
endmodule

// File: rtl/sdr_col_gen.sv
module sdr_col_gen
  import sdr_col_pkg::*;
#(
  parameter int COL_W = 8
) (
  input  logic [COL_W-1:0] base_i,
  input  logic [COL_W-1:0] beat_i,
  input  logic [COL_W-1:0] mask_i,
  input  burst_order_e     order_i,
  output logic [COL_W-1:0] col_o
);
  logic [COL_W-1:0] seq_col;
  logic [COL_W-1:0] il_col;
  logic [COL_W-1:0] sum;

  assign sum     = base_i + beat_i;
  assign seq_col = (base_i & ~mask_i) | (sum & mask_i);
  assign il_col  = base_i ^ (beat_i & mask_i);
  assign col_o   = (order_i == ORDER_IL) ? il_col : seq_col;
endmodule

// File: rtl/sdr_burst_col_seq.sv
module sdr_burst_col_seq
  import sdr_col_pkg::*;
#(
  parameter int COL_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             term_i,
  input  logic [COL_W-1:0] start_col_i,
  input  logic [2:0]       len_code_i,
  input  logic             il_i,
  output logic [COL_W-1:0] col_o,
  output logic             valid_o,
  output logic             last_o
);
  burst_order_e     req_order;
  logic [COL_W-1:0] req_mask;
  logic             req_full;

  logic             act_q,  act_d;
  logic [COL_W-1:0] base_q, base_d;
  logic [COL_W-1:0] beat_q, beat_d;
  logic [COL_W-1:0] mask_q, mask_d;
  burst_order_e     ord_q,  ord_d;
  logic             full_q, full_d;
  logic             fin_beat;
  logic             en;

  assign req_order = il_i ? ORDER_IL : ORDER_SEQ;

  sdr_len_decode #(.COL_W(COL_W)) u_dec (
    .len_code_i (len_code_i),
    .order_i    (req_order),
    .mask_o     (req_mask),
    .full_o     (req_full)
  );

  assign fin_beat = act_q && !full_q && (beat_q == mask_q);
  assign en       = start_i || term_i || act_q;

  always_comb begin
    act_d  = act_q;
    base_d = base_q;
    beat_d = beat_q;
    mask_d = mask_q;
    ord_d  = ord_q;
    full_d = full_q;
    if (start_i) begin
      act_d  = 1'b1;
      base_d = start_col_i;
      beat_d = '0;
      mask_d = req_mask;
      ord_d  = req_order;
      full_d = req_full;
    end else if (term_i) begin
      act_d  = 1'b0;
    end else if (act_q) begin
      if (fin_beat) act_d = 1'b0;
      else          beat_d = beat_q + COL_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q  <= 1'b0;
      base_q <= '0;
      beat_q <= '0;
      mask_q <= '0;
      ord_q  <= ORDER_SEQ;
      full_q <= 1'b0;
    end else if (en) begin
      act_q  <= act_d;
      base_q <= base_d;
      beat_q <= beat_d;
      mask_q <= mask_d;
      ord_q  <= ord_d;
      full_q <= full_d;
    end
  end

  sdr_col_gen #(.COL_W(COL_W)) u_gen (
    .base_i  (base_q),
    .beat_i  (beat_q),
    .mask_i  (mask_q),
    .order_i (ord_q),
    .col_o   (col_o)
  );

  assign valid_o = act_q;
  assign last_o  = fin_beat;
endmodule

// File: rtl/sdr_burst_col_chk.sv
module sdr_burst_col_chk
  import sdr_col_pkg::*;
#(
  parameter int COL_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start_i,
  input logic             term_i,
  input logic [COL_W-1:0] start_col_i,
  input logic [COL_W-1:0] col_o,
  input logic             valid_o,
  input logic             last_o,
  input logic [COL_W-1:0] mask_q,
  input burst_order_e     ord_q,
  input logic             full_q
);
  logic steady;
  assign steady = valid_o && !last_o && !start_i && !term_i;

  assert_first_beat_R2: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> (valid_o && col_o == $past(start_col_i)));

  assert_term_stops_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (term_i && !start_i) |=> (!valid_o && !last_o));

  assert_last_ends_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (last_o && !start_i) |=> !valid_o);

  assert_no_last_full_R8: assert property (@(posedge clk) disable iff (!rst_n)
    last_o |-> (valid_o && !full_q));

  assert_seq_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (steady && ord_q == ORDER_SEQ) |=>
      (((col_o - $past(col_o)) & mask_q) == COL_W'(1) &&
       (col_o & ~mask_q) == ($past(col_o) & ~mask_q)));

  assert_il_upper_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (steady && ord_q == ORDER_IL) |=>
      ((col_o & ~mask_q) == ($past(col_o) & ~mask_q) && col_o != $past(col_o)));

  assert_full_runs_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && full_q && !start_i && !term_i) |=>
      (valid_o && col_o == $past(col_o) + COL_W'(1)));
endmodule

bind sdr_burst_col_seq sdr_burst_col_chk #(.COL_W(COL_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .start_i     (start_i),
  .term_i      (term_i),
  .start_col_i (start_col_i),
  .col_o       (col_o),
  .valid_o     (valid_o),
  .last_o      (last_o),
  .mask_q      (mask_q),
  .ord_q       (ord_q),
  .full_q      (full_q)
);

// File: tb/tb_sdr_burst_col_seq.sv
module tb_sdr_burst_col_seq;
  localparam int CLK_PERIOD = 10;
  localparam int COL_W      = 8;
  localparam int NCOL       = 1 << COL_W;

  logic             clk = 1'b0;
  logic             rst_n;
  logic             start_i, term_i, il_i;
  logic [COL_W-1:0] start_col_i;
  logic [2:0]       len_code_i;
  logic [COL_W-1:0] col_o;
  logic             valid_o, last_o;

  int    checks = 0;
  int    errors = 0;
  int    cycles = 0;
  string req    = "R1";
  bit    done   = 0;

  // reference model state
  bit m_act = 0;
  int m_base = 0, m_k = 0, m_n = 0;
  bit m_il = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sdr_burst_col_seq #(.COL_W(COL_W)) dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .term_i(term_i),
    .start_col_i(start_col_i), .len_code_i(len_code_i), .il_i(il_i),
    .col_o(col_o), .valid_o(valid_o), .last_o(last_o)
  );

  always @(posedge clk) begin
    if (!rst_n) m_act = 0;
    else if (start_i) begin
      m_act  = 1;
      m_base = int'(start_col_i);
      m_k    = 0;
      m_il   = il_i;
      if (len_code_i[2]) m_n = il_i ? 8 : 0;
      else               m_n = 1 << len_code_i[1:0];
    end else if (term_i) m_act = 0;
    else if (m_act) begin
      if (m_n != 0 && m_k == m_n - 1) m_act = 0;
      else m_k = (m_k + 1) % NCOL;
    end
  end

  function automatic int exp_col();
    if (m_n == 0)  return (m_base + m_k) % NCOL;
    if (m_il)      return m_base ^ m_k;
    return (m_base - (m_base % m_n)) + ((m_base % m_n) + m_k) % m_n;
  endfunction

  task automatic chk(input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d t=%0t", req, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("valid", int'(valid_o), int'(m_act));
      chk("last", int'(last_o), int'(m_act && m_n != 0 && m_k == m_n - 1));
      if (m_act) chk("col", int'(col_o), exp_col());
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !done) begin
      done = 1;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic go(input int col, input int code, input bit il, input bit trm);
    start_i = 1; term_i = trm; start_col_i = COL_W'(col);
    len_code_i = 3'(code); il_i = il;
    @(negedge clk);
    start_i = 0; term_i = 0;
  endtask

  task automatic stop();
    term_i = 1;
    @(negedge clk);
    term_i = 0;
  endtask

  initial begin
    rst_n = 0; start_i = 0; term_i = 0; start_col_i = '0; len_code_i = '0; il_i = 0;
    cyc(2);
    req = "R1";
    chk("reset valid", int'(valid_o), 0);
    chk("reset last", int'(last_o), 0);
    rst_n = 1;
    cyc(3);

    // R2 R3: every finite length, sequential
    for (int c = 0; c < 4; c++) begin
      req = "R3"; go(8'h35, c, 0, 0); cyc(10);
    end
    // R4: wrap inside aligned block, upper bits fixed
    req = "R4"; go(8'h2D, 3, 0, 0); cyc(10);
    req = "R4"; go(8'hFE, 2, 0, 0); cyc(6);
    // R5: interleave
    req = "R5"; go(8'h6B, 2, 1, 0); cyc(6);
    req = "R5"; go(8'h6B, 3, 1, 0); cyc(10);
    req = "R5"; go(8'hA3, 1, 1, 0); cyc(4);
    // R7: interleave with full-page codes
    for (int c = 4; c < 8; c++) begin
      req = "R7"; go(8'h13, c, 1, 0); cyc(10);
    end
    // R6: full page wrap, then R9 terminate
    req = "R6"; go(8'hFA, 4, 0, 0); cyc(300);
    req = "R9"; stop(); cyc(4);
    req = "R6"; go(8'h07, 6, 0, 0); cyc(20);
    req = "R9"; stop(); cyc(3);
    // R9: terminate mid finite burst
    req = "R9"; go(8'h40, 3, 0, 0); cyc(3); stop(); cyc(8);
    // R10: restarts on first, middle and last beat
    req = "R10"; go(8'h10, 3, 0, 0); go(8'h55, 2, 1, 0); cyc(1);
    go(8'h80, 1, 0, 0); cyc(10);
    req = "R10"; go(8'h20, 2, 0, 0); cyc(3); go(8'hC4, 3, 1, 0); cyc(10);
    req = "R10"; go(8'h90, 4, 0, 0); cyc(7); go(8'h01, 0, 0, 0); cyc(4);
    // R11: start and terminate together
    req = "R11"; go(8'h33, 2, 0, 0); cyc(1); go(8'h77, 3, 0, 1); cyc(10);
    // R8: last on single beat then idle
    req = "R8"; go(8'hFF, 0, 1, 0); cyc(3);
    req = "R8"; go(8'h0C, 3, 0, 0); cyc(10);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule